// File: doc/BRIEF.md
# Multi-Mode DMA Channel Engine

This block is one DMA channel that moves bytes or 16-bit words over a bus. It takes the bus through a request/grant pair and then runs one or two valid/ready cycles for each transfer unit. A unit in dual-address form is a read from the source followed by a write of the returned data to the destination. In single-address form a unit is one bus cycle. That cycle carries the memory address and raises an acknowledge strobe, and the strobe selects the I/O device in place of a second address. One side of every transfer is memory and the other is a fixed I/O location. The memory address follows one of three counting modes: sequential, where the address steps; idle, where it holds; and repeat, where the initial address and count reload after each short block.

Software programs four registers through a write-only configuration port. The port select `cfg_sel` picks the register: 0 is the memory address, 1 is the I/O address, 2 is the count, and 3 is control. Setting the enable bit in control arms the channel. Activation is either automatic, so that units run until the count is used up, or by rising edges on an external request line. Under automatic activation the channel either gives up the bus after every unit (cycle steal) or holds the bus for the whole transfer (burst).

Bus cycles follow valid/ready rules. The channel raises `cyc_valid` only while it holds a grant. Once raised, `cyc_valid` together with the address, direction, size, strobe and write data stays unchanged until `cyc_ready` is seen high at a clock edge. A responder applies back-pressure by holding `cyc_ready` low. For a read, the responder must present `cyc_rdata` in the same cycle as `cyc_ready`.

Top module: `dma_chan`

## Requirements
- R1: While `rst_n` is low and after reset, `bus_req`, `cyc_valid`, `done` and `blk_done` are low and the channel is disabled.
- R2: In dual-address form (control bit 6 = 0) each unit is a read cycle (`cyc_write`=0) at the source followed by a write cycle (`cyc_write`=1) at the destination, carrying the read data. Control bit 8 = 0 makes memory the source and the I/O address the destination; bit 8 = 1 swaps the two.
- R3: In sequential mode (control bits 3:2 = 0) the memory address moves by 1 for bytes or 2 for words (control bit 1 = 1) after each unit. It moves up when control bit 7 = 0 and down when bit 7 = 1. The I/O address never moves.
- R4: In idle mode (control bits 3:2 = 1) the memory address is the same for every unit.
- R5: A count field of N gives exactly N units. A field of zero means 65,536 in sequential and idle modes. In repeat mode only the low 8 bits of the field are used, and zero there means a block of 256.
- R6: In repeat mode (control bits 3:2 = 2) the block's last unit reloads the initial memory address and count and pulses `blk_done` for one cycle. It never pulses `done`, and the channel stays enabled.
- R7: In sequential and idle modes, completion of the final unit pulses `done` for one cycle and clears the enable. No further bus request follows.
- R8: In cycle-steal operation (control bit 4 = 0, or external activation), `bus_req` falls in the cycle right after the last bus cycle of each unit.
- R9: In burst operation with automatic activation (control bit 4 = 1, bit 5 = 0), `bus_req` stays high from the first unit to the last unit without a gap.
- R10: `cyc_valid` is high only while `bus_gnt` is high. Under back-pressure, `cyc_valid`, `cyc_addr` and `cyc_write` hold their values until `cyc_ready`.
- R11: In single-address form (control bit 6 = 1) each unit is one bus cycle at the memory address with `cyc_dack` high. `cyc_write` = 1 when memory is the destination (bit 8 = 1) and 0 when memory is the source.
- R12: With external activation (control bit 5 = 1), each rising edge of `ext_req` starts exactly one unit, and holding the line high starts no more.
- R13: While the channel is enabled (control bit 0 = 1), writes to the memory address, I/O address and count registers are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 memory address, 1 I/O address, 2 count, 3 control |
| cfg_wdata | input | CFG_W | Configuration write data |
| ext_req | input | 1 | External transfer request (rising edge) |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus grant |
| cyc_valid | output | 1 | Bus cycle valid |
| cyc_ready | input | 1 | Bus cycle accepted / completed |
| cyc_addr | output | ADDR_W | Bus cycle address |
| cyc_write | output | 1 | 1 = write cycle, 0 = read cycle |
| cyc_word | output | 1 | 1 = 16-bit cycle, 0 = byte cycle |
| cyc_dack | output | 1 | Single-address acknowledge strobe |
| cyc_wdata | output | DATA_W | Write data |
| cyc_rdata | input | DATA_W | Read data, valid with `cyc_ready` |
| done | output | 1 | One-cycle pulse when a sequential or idle transfer completes |
| blk_done | output | 1 | One-cycle pulse at each repeat block end |

## Verification
Byte-ascending and word-descending sequential runs separate the step size from the step direction. Swapping the memory side between source and destination shows that only the memory address moves. An idle-mode run tells a frozen address apart from a stepping one. Cycle-steal and burst runs of the same kind are told apart by how many times `bus_req` rises. Repeat mode is driven by external edges: one long held pulse, then short pulses across several blocks, with a rejected address write in between. A 257-unit single-address repeat run checks the zero-means-256 rule and the reload at the block boundary. A responder that withholds `cyc_ready` every third cycle exercises the hold rules throughout.

// File: rtl/dma_chan_pkg.sv
`timescale 1ns/1ps
package dma_chan_pkg;
  typedef enum logic [1:0] {
    CNT_SEQ  = 2'd0,
    CNT_IDLE = 2'd1,
    CNT_RPT  = 2'd2,
    CNT_RSV  = 2'd3
  } cnt_mode_e;

  // packed: first field is the most significant bit
  typedef struct packed {
    logic      mem_dst;  // bit 8
    logic      dec;      // bit 7
    logic      single;   // bit 6
    logic      ext;      // bit 5
    logic      burst;    // bit 4
    cnt_mode_e mode;     // bits 3:2
    logic      word;     // bit 1
    logic      en;       // bit 0
  } ctl_t;

  localparam int unsigned CTL_W = $bits(ctl_t);

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ASK  = 3'd1,
    ST_RD   = 3'd2,
    ST_WR   = 3'd3,
    ST_ONE  = 3'd4,
    ST_GAP  = 3'd5
  } st_e;

  localparam logic [1:0] SEL_MEM = 2'd0;
  localparam logic [1:0] SEL_IO  = 2'd1;
  localparam logic [1:0] SEL_CNT = 2'd2;
  localparam logic [1:0] SEL_CTL = 2'd3;
endpackage

// File: rtl/dma_chan_step.sv
`timescale 1ns/1ps
module dma_chan_step #(
  parameter int unsigned ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic              word,
  input  logic              dec,
  input  logic              hold,
  output logic [ADDR_W-1:0] nxt
);
  localparam logic [ADDR_W-1:0] STEP_B = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] STEP_W = ADDR_W'(2);

  logic [ADDR_W-1:0] amt;

  always_comb begin
    amt = word ? STEP_W : STEP_B;
    if (hold)      nxt = cur;
    else if (dec)  nxt = cur - amt;
    else           nxt = cur + amt;
  end
endmodule

// File: rtl/dma_chan_regs.sv
`timescale 1ns/1ps
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned RPT_W  = 8,
  parameter int unsigned CFG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              unit_done,
  output ctl_t              ctl,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] io_addr,
  output logic              last,
  output logic              done,
  output logic              blk_done
);
  localparam int unsigned REM_W = CNT_W + 1;
  localparam logic [REM_W-1:0] FULL_SEQ = REM_W'(1) << CNT_W;
  localparam logic [REM_W-1:0] FULL_RPT = REM_W'(1) << RPT_W;
  localparam logic [REM_W-1:0] ONE_LEFT = REM_W'(1);

  ctl_t              ctl_q, wr_ctl;
  logic [ADDR_W-1:0] mem_q, io_q, init_mem, mem_nxt;
  logic [CNT_W-1:0]  cnt_prog;
  logic [REM_W-1:0]  rem, init_rem, ld_val, rpt_ld, seq_ld;
  logic              arm_rise, done_q, blk_q;
  logic              unused_cfg;

  assign unused_cfg = ^cfg_wdata;
  assign wr_ctl     = ctl_t'(cfg_wdata[CTL_W-1:0]);
  assign arm_rise   = cfg_we && (cfg_sel == SEL_CTL) && wr_ctl.en && !ctl_q.en;

  always_comb begin
    rpt_ld = (cnt_prog[RPT_W-1:0] == '0) ? FULL_RPT : REM_W'(cnt_prog[RPT_W-1:0]);
    seq_ld = (cnt_prog == '0) ? FULL_SEQ : REM_W'(cnt_prog);
    ld_val = (wr_ctl.mode == CNT_RPT) ? rpt_ld : seq_ld;
  end

  dma_chan_step #(.ADDR_W(ADDR_W)) step_i (
    .cur  (mem_q),
    .word (ctl_q.word),
    .dec  (ctl_q.dec),
    .hold (ctl_q.mode == CNT_IDLE),
    .nxt  (mem_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q    <= '0;
      mem_q    <= '0;
      io_q     <= '0;
      init_mem <= '0;
      cnt_prog <= '0;
      rem      <= '0;
      init_rem <= '0;
      done_q   <= 1'b0;
      blk_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      blk_q  <= 1'b0;
      if (unit_done && ctl_q.en) begin
        if (rem == ONE_LEFT) begin
          if (ctl_q.mode == CNT_RPT) begin
            mem_q <= init_mem;
            rem   <= init_rem;
            blk_q <= 1'b1;
          end else begin
            ctl_q.en <= 1'b0;
            rem      <= '0;
            done_q   <= 1'b1;
          end
        end else begin
          mem_q <= mem_nxt;
          rem   <= rem - ONE_LEFT;
        end
      end
      if (cfg_we) begin
        case (cfg_sel)
          SEL_MEM: if (!ctl_q.en) mem_q    <= cfg_wdata[ADDR_W-1:0];
          SEL_IO:  if (!ctl_q.en) io_q     <= cfg_wdata[ADDR_W-1:0];
          SEL_CNT: if (!ctl_q.en) cnt_prog <= cfg_wdata[CNT_W-1:0];
          default: begin
            ctl_q <= wr_ctl;
            if (arm_rise) begin
              rem      <= ld_val;
              init_rem <= ld_val;
              init_mem <= mem_q;
            end
          end
        endcase
      end
    end
  end

  assign ctl      = ctl_q;
  assign mem_addr = mem_q;
  assign io_addr  = io_q;
  assign last     = (rem == ONE_LEFT);
  assign done     = done_q;
  assign blk_done = blk_q;
endmodule

// File: rtl/dma_chan_trig.sv
`timescale 1ns/1ps
module dma_chan_trig #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_req,
  input  logic arm,
  input  logic take,
  output logic pend
);
  logic sync_out, prev_q, pend_q, rise;

  if (SYNC_STAGES == 0) begin : g_nosync
    assign sync_out = ext_req;
  end else begin : g_sync
    logic [SYNC_STAGES-1:0] sr;
    always_ff @(posedge clk) begin
      if (!rst_n) sr <= '0;
      else begin
        sr[0] <= ext_req;
        for (int i = 1; i < SYNC_STAGES; i++) sr[i] <= sr[i-1];
      end
    end
    assign sync_out = sr[SYNC_STAGES-1];
  end

  assign rise = sync_out && !prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= sync_out;
      if (!arm)      pend_q <= 1'b0;
      else if (rise) pend_q <= 1'b1;
      else if (take) pend_q <= 1'b0;
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/dma_chan_fsm.sv
`timescale 1ns/1ps
module dma_chan_fsm
  import dma_chan_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_t              ctl,
  input  logic              last,
  input  logic              pend,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              bus_gnt,
  input  logic              cyc_ready,
  input  logic [DATA_W-1:0] cyc_rdata,
  output logic              bus_req,
  output logic              cyc_valid,
  output logic [ADDR_W-1:0] cyc_addr,
  output logic              cyc_write,
  output logic              cyc_word,
  output logic              cyc_dack,
  output logic [DATA_W-1:0] cyc_wdata,
  output logic              take,
  output logic              unit_done
);
  st_e               st, st_nx, first_st;
  logic [DATA_W-1:0] hold_q;
  logic              go, is_rpt, keep_bus, unit_end;

  assign is_rpt   = (ctl.mode == CNT_RPT);
  assign go       = ctl.en && (ctl.ext ? pend : 1'b1);
  assign keep_bus = ctl.burst && !ctl.ext && ctl.en && !last;
  assign first_st = ctl.single ? ST_ONE : ST_RD;
  assign unit_end = cyc_ready && ((st == ST_WR) || (st == ST_ONE));

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE: if (go) st_nx = ST_ASK;
      ST_ASK:  if (bus_gnt) st_nx = first_st;
      ST_RD:   if (cyc_ready) st_nx = ST_WR;
      ST_WR, ST_ONE: begin
        if (cyc_ready) begin
          if (last && !is_rpt) st_nx = ST_IDLE;
          else if (keep_bus)   st_nx = first_st;
          else                 st_nx = ST_GAP;
        end
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      hold_q <= '0;
    end else begin
      st <= st_nx;
      if ((st == ST_RD) && cyc_ready) hold_q <= cyc_rdata;
    end
  end

  always_comb begin
    cyc_valid = 1'b0;
    cyc_addr  = '0;
    cyc_write = 1'b0;
    cyc_dack  = 1'b0;
    cyc_wdata = '0;
    case (st)
      ST_RD: begin
        cyc_valid = 1'b1;
        cyc_addr  = ctl.mem_dst ? io_addr : mem_addr;
      end
      ST_WR: begin
        cyc_valid = 1'b1;
        cyc_addr  = ctl.mem_dst ? mem_addr : io_addr;
        cyc_write = 1'b1;
        cyc_wdata = hold_q;
      end
      ST_ONE: begin
        cyc_valid = 1'b1;
        cyc_addr  = mem_addr;
        cyc_write = ctl.mem_dst;
        cyc_dack  = 1'b1;
      end
      default: ;
    endcase
  end

  assign bus_req   = (st == ST_ASK) || (st == ST_RD) || (st == ST_WR) || (st == ST_ONE);
  assign cyc_word  = ctl.word;
  assign take      = (st == ST_IDLE) && go && ctl.ext;
  assign unit_done = unit_end;
endmodule

// File: rtl/dma_chan.sv
`timescale 1ns/1ps
module dma_chan
  import dma_chan_pkg::*;
#(
  parameter int unsigned ADDR_W      = 24,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned RPT_W       = 8,
  parameter int unsigned CFG_W       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              ext_req,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              cyc_valid,
  input  logic              cyc_ready,
  output logic [ADDR_W-1:0] cyc_addr,
  output logic              cyc_write,
  output logic              cyc_word,
  output logic              cyc_dack,
  output logic [DATA_W-1:0] cyc_wdata,
  input  logic [DATA_W-1:0] cyc_rdata,
  output logic              done,
  output logic              blk_done
);
  ctl_t              ctl;
  logic [ADDR_W-1:0] mem_addr, io_addr;
  logic              last, pend, take, unit_done;
  logic              steal_mode;

  assign steal_mode = !ctl.burst || ctl.ext;

  dma_chan_regs #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .RPT_W  (RPT_W),
    .CFG_W  (CFG_W)
  ) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .unit_done (unit_done),
    .ctl       (ctl),
    .mem_addr  (mem_addr),
    .io_addr   (io_addr),
    .last      (last),
    .done      (done),
    .blk_done  (blk_done)
  );

  dma_chan_trig #(.SYNC_STAGES(SYNC_STAGES)) trig_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .ext_req (ext_req),
    .arm     (ctl.en && ctl.ext),
    .take    (take),
    .pend    (pend)
  );

  dma_chan_fsm #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) fsm_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .last      (last),
    .pend      (pend),
    .mem_addr  (mem_addr),
    .io_addr   (io_addr),
    .bus_gnt   (bus_gnt),
    .cyc_ready (cyc_ready),
    .cyc_rdata (cyc_rdata),
    .bus_req   (bus_req),
    .cyc_valid (cyc_valid),
    .cyc_addr  (cyc_addr),
    .cyc_write (cyc_write),
    .cyc_word  (cyc_word),
    .cyc_dack  (cyc_dack),
    .cyc_wdata (cyc_wdata),
    .take      (take),
    .unit_done (unit_done)
  );
endmodule

// File: rtl/dma_chan_chk.sv
`timescale 1ns/1ps
module dma_chan_chk #(
  parameter int unsigned ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic              cyc_valid,
  input logic              cyc_ready,
  input logic [ADDR_W-1:0] cyc_addr,
  input logic              cyc_write,
  input logic              cyc_dack,
  input logic              done,
  input logic              blk_done,
  input logic              steal_mode
);
  assert_grant_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |-> bus_gnt);

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && !cyc_ready) |=> (cyc_valid && $stable(cyc_addr) &&
                                   $stable(cyc_write) && $stable(cyc_dack)));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_steal_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_ready && (cyc_write || cyc_dack) && steal_mode) |=> !bus_req);

  assert_single_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_ready && cyc_dack) |=> (!cyc_valid || cyc_dack));

  assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && blk_done));
endmodule

bind dma_chan dma_chan_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_req    (bus_req),
  .bus_gnt    (bus_gnt),
  .cyc_valid  (cyc_valid),
  .cyc_ready  (cyc_ready),
  .cyc_addr   (cyc_addr),
  .cyc_write  (cyc_write),
  .cyc_dack   (cyc_dack),
  .done       (done),
  .blk_done   (blk_done),
  .steal_mode (steal_mode)
);

// File: tb/dma_chan_tb_top.sv
`timescale 1ns/1ps
module dma_chan_tb_top;
  localparam int CLK_P = 10;

  typedef struct {
    logic [23:0] a;
    bit          wr;
    bit          dack;
    bit          chk;
    logic [15:0] d;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        ext_req = 1'b0;
  logic        bus_req, bus_gnt = 1'b0;
  logic        cyc_valid, cyc_ready = 1'b0;
  logic [23:0] cyc_addr;
  logic        cyc_write, cyc_word, cyc_dack;
  logic [15:0] cyc_wdata, cyc_rdata = '0;
  logic        done, blk_done;

  item_t exp_q[$];
  int    n_chk = 0, n_bad = 0, n_pop = 0;
  int    req_rises = 0, done_cnt = 0, blk_cnt = 0, phase = 0;
  string cur_tag = "R1";
  bit    finished = 1'b0;
  logic        pv = 1'b0, pr = 1'b0, pw = 1'b0, preq = 1'b0;
  logic [23:0] pa = '0;

  always #(CLK_P/2) clk = ~clk;

  dma_chan dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .ext_req(ext_req), .bus_req(bus_req), .bus_gnt(bus_gnt), .cyc_valid(cyc_valid),
    .cyc_ready(cyc_ready), .cyc_addr(cyc_addr), .cyc_write(cyc_write), .cyc_word(cyc_word),
    .cyc_dack(cyc_dack), .cyc_wdata(cyc_wdata), .cyc_rdata(cyc_rdata), .done(done),
    .blk_done(blk_done)
  );

  function automatic logic [15:0] rd_val(input logic [23:0] a);
    return a[15:0] ^ 16'h5A3C;
  endfunction

  function automatic logic [31:0] mk_ctl(input bit en, word, input logic [1:0] mode,
                                         input bit burst, ext, single, dec, mem_dst);
    return {23'd0, mem_dst, dec, single, ext, burst, mode, word, en};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // driver: expected bus cycles computed from the requirements
  task automatic push_units(input logic [23:0] m0, io, input int block, total,
                            input bit word, hold, dec, mem_dst, single);
    logic [23:0] a, src, dst, stp;
    item_t it;
    stp = word ? 24'd2 : 24'd1;
    a = m0;
    for (int k = 0; k < total; k++) begin
      if (k % block == 0) a = m0;
      src = mem_dst ? io : a;
      dst = mem_dst ? a : io;
      if (single) begin
        it = '{a: a, wr: mem_dst, dack: 1'b1, chk: 1'b0, d: 16'h0};
        exp_q.push_back(it);
      end else begin
        it = '{a: src, wr: 1'b0, dack: 1'b0, chk: 1'b0, d: 16'h0};
        exp_q.push_back(it);
        it = '{a: dst, wr: 1'b1, dack: 1'b0, chk: 1'b1, d: rd_val(src)};
        exp_q.push_back(it);
      end
      if (!hold) a = dec ? a - stp : a + stp;
    end
  endtask

  // monitor and bus responder
  always @(negedge clk) begin
    bit    rdy;
    item_t e;
    phase++;
    rdy = (phase % 3 != 1);
    if (cyc_valid)
      check(bus_gnt === 1'b1, "R10", "valid without grant", bus_gnt, 1);
    if (pv && !pr)
      check(cyc_valid === 1'b1 && cyc_addr === pa && cyc_write === pw, "R10",
            "stalled cycle changed", cyc_addr, pa);
    cyc_ready = rdy;
    cyc_rdata = rd_val(cyc_addr);
    if (cyc_valid && rdy) begin
      if (exp_q.size() == 0) begin
        check(1'b0, cur_tag, "unexpected bus cycle addr", cyc_addr, 0);
      end else begin
        e = exp_q.pop_front();
        n_pop++;
        check(cyc_addr === e.a, cur_tag, "cycle address", cyc_addr, e.a);
        check(cyc_write === e.wr && cyc_dack === e.dack, cur_tag, "cycle kind write/dack",
              {cyc_write, cyc_dack}, {e.wr, e.dack});
        if (e.chk) check(cyc_wdata === e.d, cur_tag, "write data", cyc_wdata, e.d);
      end
    end
    if (bus_req && !preq) req_rises++;
    if (done) done_cnt++;
    if (blk_done) blk_cnt++;
    pv = cyc_valid; pr = rdy; pa = cyc_addr; pw = cyc_write; preq = bus_req;
    bus_gnt = bus_req;
  end

  task automatic cfg_wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse(input int hi, input int lo);
    @(negedge clk);
    ext_req = 1'b1;
    repeat (hi) @(negedge clk);
    ext_req = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired, queue depth actual=%0d expected=0", exp_q.size());
      summary();
      $finish;
    end
  end

  initial begin
    int r0, d0, b0, p0;
    // R1: reset state
    repeat (4) @(negedge clk);
    check({bus_req, cyc_valid, done, blk_done} === 4'b0, "R1", "outputs in reset",
          {bus_req, cyc_valid, done, blk_done}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check({bus_req, cyc_valid, done, blk_done} === 4'b0, "R1", "outputs after reset",
          {bus_req, cyc_valid, done, blk_done}, 0);

    // R2 R3 R8 R7: sequential byte ascending, memory source, cycle steal
    cur_tag = "R2 R3";
    cfg_wr(2'd0, 32'h001000);
    cfg_wr(2'd1, 32'h00F000);
    cfg_wr(2'd2, 32'd4);
    push_units(24'h001000, 24'h00F000, 4, 4, 0, 0, 0, 0, 0);
    r0 = req_rises; d0 = done_cnt;
    cfg_wr(2'd3, mk_ctl(1, 0, 2'd0, 0, 0, 0, 0, 0));
    drain();
    check(req_rises - r0 == 4, "R8", "bus requests per steal run", req_rises - r0, 4);
    check(done_cnt - d0 == 1, "R7", "done pulses", done_cnt - d0, 1);
    r0 = req_rises;
    repeat (30) @(negedge clk);
    check(req_rises == r0 && bus_req == 1'b0, "R7", "request after completion", req_rises - r0, 0);

    // R3 R9: word descending, memory destination, burst
    cur_tag = "R3 R9";
    cfg_wr(2'd0, 32'h002000);
    cfg_wr(2'd1, 32'h000040);
    cfg_wr(2'd2, 32'd3);
    push_units(24'h002000, 24'h000040, 3, 3, 1, 0, 1, 1, 0);
    r0 = req_rises; d0 = done_cnt;
    cfg_wr(2'd3, mk_ctl(1, 1, 2'd0, 1, 0, 0, 1, 1));
    drain();
    check(req_rises - r0 == 1, "R9", "bus requests per burst run", req_rises - r0, 1);
    check(done_cnt - d0 == 1, "R7", "done pulses burst", done_cnt - d0, 1);

    // R4: idle mode keeps the memory address
    cur_tag = "R4";
    cfg_wr(2'd0, 32'h005000);
    cfg_wr(2'd1, 32'h000080);
    cfg_wr(2'd2, 32'd3);
    push_units(24'h005000, 24'h000080, 3, 3, 1, 1, 0, 0, 0);
    d0 = done_cnt;
    cfg_wr(2'd3, mk_ctl(1, 1, 2'd1, 0, 0, 0, 0, 0));
    drain();
    check(done_cnt - d0 == 1, "R4", "idle run completes", done_cnt - d0, 1);

    // R6 R12 R13: repeat mode, external edges, block of 2
    cur_tag = "R6 R12";
    cfg_wr(2'd0, 32'h003000);
    cfg_wr(2'd1, 32'h00A000);
    cfg_wr(2'd2, 32'd2);
    push_units(24'h003000, 24'h00A000, 2, 6, 0, 0, 0, 0, 0);
    b0 = blk_cnt; d0 = done_cnt;
    cfg_wr(2'd3, mk_ctl(1, 0, 2'd2, 0, 1, 0, 0, 0));
    p0 = n_pop;
    pulse(40, 20);
    check(n_pop - p0 == 2, "R12", "cycles from one held request", n_pop - p0, 2);
    for (int i = 0; i < 4; i++) pulse(2, 16);
    cur_tag = "R13";
    cfg_wr(2'd0, 32'h007777);
    pulse(2, 16);
    drain();
    check(blk_cnt - b0 == 3, "R6", "block pulses", blk_cnt - b0, 3);
    check(done_cnt - d0 == 0, "R6", "no done in repeat", done_cnt - d0, 0);
    cfg_wr(2'd3, 32'h0);
    p0 = n_pop;
    pulse(2, 20);
    check(n_pop == p0, "R12", "edge ignored when disabled", n_pop - p0, 0);

    // R5 R11: single address, repeat count field 0x300 -> block of 256
    cur_tag = "R5 R11";
    cfg_wr(2'd0, 32'h008000);
    cfg_wr(2'd2, 32'h0300);
    push_units(24'h008000, 24'h0, 256, 257, 0, 0, 0, 0, 1);
    b0 = blk_cnt;
    cfg_wr(2'd3, mk_ctl(1, 0, 2'd2, 0, 1, 1, 0, 0));
    for (int i = 0; i < 255; i++) pulse(2, 10);
    check(blk_cnt - b0 == 0, "R5", "block pulse before unit 256", blk_cnt - b0, 0);
    pulse(2, 12);
    check(blk_cnt - b0 == 1, "R5", "block pulse after unit 256", blk_cnt - b0, 1);
    pulse(2, 12);
    drain();
    cfg_wr(2'd3, 32'h0);

    // R11 R5: single address, auto burst, word descending, memory destination
    cur_tag = "R11 R5";
    cfg_wr(2'd0, 32'h006000);
    cfg_wr(2'd2, 32'd5);
    push_units(24'h006000, 24'h0, 5, 5, 1, 0, 1, 1, 1);
    d0 = done_cnt; r0 = req_rises;
    cfg_wr(2'd3, mk_ctl(1, 1, 2'd0, 1, 0, 1, 1, 1));
    drain();
    check(done_cnt - d0 == 1, "R5", "done after five units", done_cnt - d0, 1);
    check(req_rises - r0 == 1, "R9", "single-address burst requests", req_rises - r0, 1);
    check(exp_q.size() == 0, "R11", "expected cycles left", exp_q.size(), 0);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule